// File: doc/BRIEF.md
# SPI Master Timing Sequencer

This block is the timing engine of an SPI master running from one master clock. A programmable modulus divider, with an optional divide-by-32 prescaler, sets the serial clock. The sequencer drops the active-low chip select, waits a programmable lead time, and emits the sixteen serial clock edges of one 8-bit character. After the character it holds a programmable gap and then pulses a done strobe. Along with each clock edge it raises a one-cycle strobe: a shift strobe on the leading edge and a sample strobe on the trailing edge. The shift register that uses these strobes sits outside the block.

A request carries a keep flag. When the flag is low, chip select rises together with the done pulse. When it is high, chip select stays low, and the next request starts its clock burst after only half a serial period, with no programmed lead time. The configuration fields are captured when a request is accepted, so software may rewrite them while a character is in flight.

Top module: `spi_timing_seq`

## Requirements
- R1: With the prescaler off, each half period of the serial clock lasts `cfg_div` master cycles. With it on, each half period lasts 32×`cfg_div` cycles. The full serial period is twice the half period.
- R2: A `cfg_div` value of 0 or 1 disables the generator. A request seen in that case is ignored: chip select stays high, the serial clock stays at `cfg_cpol`, and no strobe or done pulse appears.
- R3: During and right after reset, `cs_n` is 1, `sclk` is 0, and `shift_stb`, `sample_stb` and `done` are 0.
- R4: An accepted request drives `cs_n` low on the next cycle. The first serial clock edge comes `cfg_pre_dly` cycles later (×32 when prescaled). A zero field gives a delay of one half period.
- R5: Each character has exactly 16 serial clock edges. The odd-numbered edges (the serial clock leaves `cfg_cpol`) come with a one-cycle `shift_stb`. The even-numbered edges (it returns to `cfg_cpol`) come with a one-cycle `sample_stb`. Both strobes appear in the same cycle as the edge.
- R6: After the 16th edge the block waits 32×`cfg_gap_dly` cycles (×1024 when prescaled), or 4 cycles (128 when prescaled) if the field is zero. At the end of this wait, `done` is high for exactly one cycle.
- R7: If keep was 0, `cs_n` rises in the same cycle as `done`. If keep was 1, `cs_n` stays low. The next accepted request then produces its first edge one half period after acceptance.
- R8: Configuration inputs that change after a request is accepted have no effect on that character's timing.
- R9: A request that arrives while a character is in progress is ignored. It produces no additional done pulse.
- R10: While no character is in progress, `sclk` follows `cfg_cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 8 | Serial clock divider (2..255 legal) |
| cfg_pre_dly | input | 8 | Lead time from chip select to first edge |
| cfg_gap_dly | input | 8 | Gap after each character |
| cfg_prescale | input | 1 | Selects the divide-by-32 prescaler |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| req | input | 1 | Start one character (sampled when idle) |
| req_keep | input | 1 | Keep chip select low after this character |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| shift_stb | output | 1 | One-cycle strobe on leading edges |
| sample_stb | output | 1 | One-cycle strobe on trailing edges |
| done | output | 1 | One-cycle pulse at the end of a character |

## Verification
The bench sweeps divider, lead and gap settings, including both zero-field defaults and prescaled runs, and predicts cycle by cycle where every clock edge, strobe, chip-select change and done pulse must fall. An off-by-one in any counter shifts every later event and is caught at the first misplaced edge. A design that ignored a zero field would run with a zero-length lead or gap. A design that mixed up the strobes would show a shift strobe on a trailing edge. Further tests rewrite the configuration and raise a request in mid-character, chain characters with the keep flag set, and present divider values 0 and 1. A design that read live configuration, accepted requests while busy, released chip select too early or started on a disabled divider would show a wrong edge spacing, an extra done pulse or a chip-select change.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_LEAD  = 2'd1,
        SQ_BURST = 2'd2,
        SQ_GAP   = 2'd3
    } sq_state_e;

    localparam int PS_LOG2       = 5;  // prescaler divides by 32
    localparam int GAP_UNIT_LOG2 = 5;  // gap field counts 32-cycle units
    localparam int MIN_GAP       = 4;  // gap when field is zero
    localparam int MIN_DIV       = 2;  // smallest enabled divider
endpackage

// File: rtl/spi_seq_lengths.sv
module spi_seq_lengths
    import spi_seq_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int DLY_W = 8,
    parameter int GAP_W = 8,
    parameter int CNT_W = 19
) (
    input  logic [DIV_W-1:0] div,
    input  logic [DLY_W-1:0] pre,
    input  logic [GAP_W-1:0] gap,
    input  logic             prescale,
    input  logic             held,
    output logic [CNT_W-1:0] half_len,
    output logic [CNT_W-1:0] lead_len,
    output logic [CNT_W-1:0] gap_len
);
    int unsigned sh;

    always_comb begin
        sh       = prescale ? PS_LOG2 : 0;
        half_len = CNT_W'(div) << sh;
        if (held || pre == '0) lead_len = half_len;
        else                   lead_len = CNT_W'(pre) << sh;
        if (gap == '0) gap_len = CNT_W'(MIN_GAP) << sh;
        else           gap_len = CNT_W'(gap) << (GAP_UNIT_LOG2 + sh);
    end
endmodule

// File: rtl/spi_seq_timer.sv
module spi_seq_timer #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)             cnt_d = load_val - W'(1);
        else if (cnt_q != '0) cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R1: a loaded count never rises on its own
    a_r1_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/spi_timing_seq.sv
module spi_timing_seq
    import spi_seq_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int DLY_W = 8,
    parameter int GAP_W = 8,
    parameter int BITS  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [DLY_W-1:0] cfg_pre_dly,
    input  logic [GAP_W-1:0] cfg_gap_dly,
    input  logic             cfg_prescale,
    input  logic             cfg_cpol,
    input  logic             req,
    input  logic             req_keep,
    output logic             sclk,
    output logic             cs_n,
    output logic             shift_stb,
    output logic             sample_stb,
    output logic             done
);
    localparam int EDGES   = 2 * BITS;
    localparam int EC_W    = $clog2(EDGES) + 1;
    localparam int BASE_W  = (DIV_W > DLY_W) ? DIV_W : DLY_W;
    localparam int GAPX_W  = GAP_W + GAP_UNIT_LOG2;
    localparam int CNT_W   = ((BASE_W > GAPX_W) ? BASE_W : GAPX_W) + PS_LOG2 + 1;

    typedef struct packed {
        sq_state_e        st;
        logic [DIV_W-1:0] div;
        logic [DLY_W-1:0] pre;
        logic [GAP_W-1:0] gap;
        logic             ps;
        logic             keep;
        logic             held;
        logic             sclk;
        logic             cs_n;
        logic             shift;
        logic             sample;
        logic             done;
        logic [EC_W-1:0]  ecnt;
    } seq_t;

    seq_t q, d;

    logic             idle;
    logic [DIV_W-1:0] c_div;
    logic [DLY_W-1:0] c_pre;
    logic [GAP_W-1:0] c_gap;
    logic             c_ps;
    logic [CNT_W-1:0] half_len, lead_len, gap_len, ld_val;
    logic             ld, tmr_zero;

    assign idle = (q.st == SQ_IDLE);

    // Live config feeds the lengths while idle, captured config otherwise
    always_comb begin
        c_div = idle ? cfg_div      : q.div;
        c_pre = idle ? cfg_pre_dly  : q.pre;
        c_gap = idle ? cfg_gap_dly  : q.gap;
        c_ps  = idle ? cfg_prescale : q.ps;
    end

    spi_seq_lengths #(
        .DIV_W(DIV_W), .DLY_W(DLY_W), .GAP_W(GAP_W), .CNT_W(CNT_W)
    ) u_len (
        .div(c_div), .pre(c_pre), .gap(c_gap), .prescale(c_ps), .held(q.held),
        .half_len(half_len), .lead_len(lead_len), .gap_len(gap_len)
    );

    spi_seq_timer #(.W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .zero(tmr_zero)
    );

    always_comb begin
        d        = q;
        d.shift  = 1'b0;
        d.sample = 1'b0;
        d.done   = 1'b0;
        ld       = 1'b0;
        ld_val   = '0;
        unique case (q.st)
            SQ_IDLE: begin
                d.sclk = cfg_cpol;
                if (req && cfg_div >= DIV_W'(MIN_DIV)) begin
                    d.st   = SQ_LEAD;
                    d.div  = cfg_div;
                    d.pre  = cfg_pre_dly;
                    d.gap  = cfg_gap_dly;
                    d.ps   = cfg_prescale;
                    d.sclk = cfg_cpol;
                    d.keep = req_keep;
                    d.cs_n = 1'b0;
                    d.ecnt = '0;
                    ld     = 1'b1;
                    ld_val = lead_len;
                end
            end
            SQ_LEAD: begin
                if (tmr_zero) begin
                    d.st    = SQ_BURST;
                    d.sclk  = ~q.sclk;
                    d.shift = 1'b1;
                    d.ecnt  = EC_W'(1);
                    ld      = 1'b1;
                    ld_val  = half_len;
                end
            end
            SQ_BURST: begin
                if (tmr_zero) begin
                    d.sclk   = ~q.sclk;
                    d.ecnt   = q.ecnt + EC_W'(1);
                    d.sample = q.ecnt[0];
                    d.shift  = ~q.ecnt[0];
                    ld       = 1'b1;
                    if (q.ecnt == EC_W'(EDGES - 1)) begin
                        d.st   = SQ_GAP;
                        ld_val = gap_len;
                    end else begin
                        ld_val = half_len;
                    end
                end
            end
            SQ_GAP: begin
                if (tmr_zero) begin
                    d.st   = SQ_IDLE;
                    d.done = 1'b1;
                    d.cs_n = ~q.keep;
                    d.held = q.keep;
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk       = q.sclk;
    assign cs_n       = q.cs_n;
    assign shift_stb  = q.shift;
    assign sample_stb = q.sample;
    assign done       = q.done;

    // R5: the two strobes are never raised together
    a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_stb && sample_stb));
    // R5: every strobe coincides with a change of the serial clock
    a_r5_strobe_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_stb || sample_stb) |-> (sclk != $past(sclk)));
    // R6: done lasts a single cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: chip select is released only together with done
    a_r7_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> done);
    // R4: chip select falls only after a request
    a_r4_cs_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(req));
    // R2: a disabled divider keeps an idle, released chip select high
    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && cs_n && cfg_div < DIV_W'(MIN_DIV)) |=> cs_n);
endmodule

// File: tb/spi_timing_seq_tb.sv
module spi_timing_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_div = 8'd0, cfg_pre_dly = 8'd0, cfg_gap_dly = 8'd0;
    logic       cfg_prescale = 1'b0, cfg_cpol = 1'b0;
    logic       req = 1'b0, req_keep = 1'b0;
    logic       sclk, cs_n, shift_stb, sample_stb, done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spi_timing_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_pre_dly(cfg_pre_dly),
        .cfg_gap_dly(cfg_gap_dly), .cfg_prescale(cfg_prescale), .cfg_cpol(cfg_cpol),
        .req(req), .req_keep(req_keep), .sclk(sclk), .cs_n(cs_n),
        .shift_stb(shift_stb), .sample_stb(sample_stb), .done(done)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // One character; called at a negedge, returns at a negedge with the DUT idle
    task automatic run_xfer(input int div, input int pre, input int gap, input int ps,
                            input int cpol, input int keep, input int held,
                            input int disturb, input string tag);
        int s, h, l, g, kd;
        int bc, bs, bcs, bd, ndone;
        int k_c, a_c, e_c, k_s, a_s, e_s, k_cs, a_cs, k_d;
        s  = ps ? 32 : 1;
        h  = div * s;
        l  = (held != 0 || pre == 0) ? h : pre * s;
        g  = (gap == 0) ? 4 * s : 32 * gap * s;
        kd = l + 15 * h + g;
        bc = 0; bs = 0; bcs = 0; bd = 0; ndone = 0;
        k_c = 0; a_c = 0; e_c = 0; k_s = 0; a_s = 0; e_s = 0; k_cs = 0; a_cs = 0; k_d = 0;
        cfg_div = 8'(div); cfg_pre_dly = 8'(pre); cfg_gap_dly = 8'(gap);
        cfg_prescale = 1'(ps); cfg_cpol = 1'(cpol);
        req = 1'b1; req_keep = 1'(keep);
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        for (int k = 1; k <= kd + 2; k++) begin
            int t, nedge, ex_sclk, ex_sh, ex_sa, ex_cs, ex_dn, is_edge, idx;
            if (k > 1) @(negedge clk);
            if (disturb != 0 && k == 3) begin
                req = 1'b1; cfg_div = 8'd9; cfg_pre_dly = 8'd7;
                cfg_gap_dly = 8'd3; cfg_prescale = ~cfg_prescale;
            end
            if (disturb != 0 && k == 4) req = 1'b0;
            t       = k - 1 - l;
            is_edge = (t >= 0 && (t % h) == 0 && (t / h) < 16) ? 1 : 0;
            idx     = (t >= 0) ? t / h + 1 : 0;
            nedge   = (t < 0) ? 0 : ((idx > 16) ? 16 : idx);
            ex_sclk = cpol ^ (nedge % 2);
            ex_sh   = (is_edge != 0 && (idx % 2) == 1) ? 1 : 0;
            ex_sa   = (is_edge != 0 && (idx % 2) == 0) ? 1 : 0;
            ex_cs   = (k <= kd) ? 0 : (keep != 0 ? 0 : 1);
            ex_dn   = (k == kd + 1) ? 1 : 0;
            if (done) ndone++;
            if (int'(sclk) != ex_sclk && bc == 0) begin bc = 1; k_c = k; a_c = sclk; e_c = ex_sclk; end
            if ((int'(shift_stb) != ex_sh || int'(sample_stb) != ex_sa) && bs == 0) begin
                bs = 1; k_s = k; a_s = 2 * shift_stb + sample_stb; e_s = 2 * ex_sh + ex_sa;
            end
            if (int'(cs_n) != ex_cs && bcs == 0) begin bcs = 1; k_cs = k; a_cs = cs_n; end
            if (int'(done) != ex_dn && bd == 0) begin bd = 1; k_d = k; end
        end
        chk(bc == 0, $sformatf("R1 sclk edge timing (%s) cycle %0d", tag, k_c), a_c, e_c);
        chk(bs == 0, $sformatf("R5 strobes {shift,sample} (%s) cycle %0d", tag, k_s), a_s, e_s);
        chk(bcs == 0, $sformatf("R4/R7 cs_n (%s) cycle %0d", tag, k_cs), a_cs, 1 - a_cs);
        chk(bd == 0, $sformatf("R6 done timing (%s) cycle %0d", tag, k_d), bd, 0);
        if (disturb != 0)
            chk(ndone == 1, $sformatf("R9 done pulses with busy request (%s)", tag), ndone, 1);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int cfg_i;
        // R3: reset state
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R3 cs_n/sclk in reset", 2 * cs_n + sclk, 2);
        chk(!shift_stb && !sample_stb && !done, "R3 strobes/done in reset",
            int'(shift_stb) + int'(sample_stb) + int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0 && !done, "R3 state after reset", 2 * cs_n + sclk, 2);

        // R10: idle clock follows polarity
        cfg_cpol = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b1, "R10 idle sclk follows cpol=1", sclk, 1);
        cfg_cpol = 1'b0;
        @(negedge clk);
        chk(sclk == 1'b0, "R10 idle sclk follows cpol=0", sclk, 0);

        // R2: divider 0 and 1 block requests
        for (int dv = 0; dv < 2; dv++) begin
            int bad;
            bad = 0;
            cfg_div = 8'(dv); cfg_cpol = 1'(dv); cfg_pre_dly = 8'd1; req = 1'b1;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (k == 2) req = 1'b0;
                if (k > 0 && (cs_n != 1'b1 || sclk != 1'(dv) || done || shift_stb || sample_stb)) bad++;
            end
            chk(bad == 0, $sformatf("R2 disabled divider %0d ignores request", dv), bad, 0);
        end

        // R1 R4 R5 R6: sweep without prescaler
        cfg_i = 0;
        for (int dv = 2; dv <= 5; dv += (dv == 2) ? 1 : 2) begin
            for (int pr = 0; pr <= 3; pr += (pr == 0) ? 1 : 2) begin
                for (int gp = 0; gp <= 1; gp++) begin
                    run_xfer(dv, pr, gp, 0, cfg_i % 2, 0, 0, 0, "sweep");
                    cfg_i++;
                end
            end
        end

        // R1 R4 R6 with prescaler
        for (int pr = 0; pr <= 2; pr += 2) begin
            for (int gp = 0; gp <= 1; gp++) begin
                run_xfer(2, pr, gp, 1, pr / 2, 0, 0, 0, "prescaled");
            end
        end

        // R8 R9: configuration rewritten and request raised mid-character
        run_xfer(3, 2, 1, 0, 0, 0, 0, 1, "R8 config change");

        // R7: chained characters with chip select kept
        run_xfer(2, 5, 0, 0, 1, 1, 0, 0, "R7 keep first");
        run_xfer(3, 5, 0, 0, 1, 1, 1, 0, "R7 keep middle");
        run_xfer(2, 5, 1, 0, 1, 0, 1, 0, "R7 keep release");

        summary();
        $finish;
    end
endmodule